// File: doc/BRIEF.md
# Command Byte Report Formatter

This block turns one 8-bit command value into a fixed ASCII report line. It sends that line one byte at a time over a valid/ready byte stream, which is meant to feed a UART transmitter. A start strobe, taken while the block is idle, captures the value.

The line has a fixed shape:
- the literal `NEC command: 0x`;
- the value as two uppercase hex digits;
- a space, then the value in decimal without leading zeros inside parentheses;
- carriage return and line feed.

The decimal digits come from a short sequential stage that subtracts 100 and then 10. This stage runs before the first byte is presented, so no divider is needed. Lines are 23 to 25 bytes long, depending on how many decimal digits the value has.

The block takes one command at a time. While a line is in progress it reports busy and drops any further start strobes.

Top module: `cmd_report_fmt`

## Requirements
- R1: After reset, `busy_o` and `tx_valid_o` are low.
- R2: Bytes 0 to 14 of every line are the ASCII text `NEC command: 0x`. The first byte is 0x4E.
- R3: Bytes 15 and 16 are the high nibble and then the low nibble of the captured value as ASCII hex. Nibbles 0 to 9 map to 0x30 to 0x39 and nibbles 10 to 15 map to 0x41 to 0x46.
- R4: Bytes 17 and 18 are 0x20 and 0x28. The decimal value follows with no leading zeros, most significant digit first: three digits for values of 100 or more, two for values of 10 to 99, one digit otherwise.
- R5: After the decimal digits come 0x29, 0x0D and 0x0A. The line length is therefore 23, 24 or 25 bytes for one, two or three decimal digits.
- R6: While `tx_valid_o` is high and `tx_ready_i` is low, the same byte stays on `tx_data_o` and `tx_valid_o` stays high. The block moves to the next byte only after a cycle in which both are high.
- R7: `busy_o` rises in the cycle after a start is accepted. A start strobe that arrives while `busy_o` is high is ignored and does not change the line being sent.
- R8: `busy_o` and `tx_valid_o` are low in the cycle after the line-feed byte is accepted. A start strobe after that point begins a new line.
- R9: The first byte of a line is presented no more than 20 cycles after the start strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture `cmd_i` and begin a line (only while idle) |
| cmd_i | input | 8 | Command value to report |
| busy_o | output | 1 | High from the accepted start until the line feed is taken |
| tx_data_o | output | 8 | Current ASCII byte |
| tx_valid_o | output | 1 | `tx_data_o` holds a byte to send |
| tx_ready_i | input | 1 | The sink takes the byte in this cycle |

## Verification
`busy_o` is due one edge after the start strobe, so the bench samples it on the falling edge that follows the strobe. The first byte is due after the digit-split stage has finished; the bench allows that for up to 20 cycles, because the stage's run time depends on the value.

Each later byte is due one edge after the previous handshake. The bench drives `tx_ready_i` on the falling edge and records a byte only when both valid and ready are seen high at that same falling edge. A stalled byte is compared against itself at the next falling edge.

The idle state after the line feed is checked on the falling edge right after the line-feed handshake. All 256 values are swept under a changing stall pattern, and a start strobe carrying a different value is pushed into every fifth line in the middle of the line.

// File: rtl/cmd_fmt_pkg.sv
package cmd_fmt_pkg;
  localparam int unsigned PREFIX_LEN = 15;
  localparam int unsigned IDX_W = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_EMIT} fmt_state_e;

  function automatic logic [7:0] prefix_char(input logic [IDX_W-1:0] i);
    case (i)
      5'd0:  prefix_char = 8'h4E;
      5'd1:  prefix_char = 8'h45;
      5'd2:  prefix_char = 8'h43;
      5'd3:  prefix_char = 8'h20;
      5'd4:  prefix_char = 8'h63;
      5'd5:  prefix_char = 8'h6F;
      5'd6:  prefix_char = 8'h6D;
      5'd7:  prefix_char = 8'h6D;
      5'd8:  prefix_char = 8'h61;
      5'd9:  prefix_char = 8'h6E;
      5'd10: prefix_char = 8'h64;
      5'd11: prefix_char = 8'h3A;
      5'd12: prefix_char = 8'h20;
      5'd13: prefix_char = 8'h30;
      default: prefix_char = 8'h78;
    endcase
  endfunction

  function automatic logic [7:0] hex_ascii(input logic [3:0] n);
    hex_ascii = (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/cmd_bcd_split.sv
module cmd_bcd_split #(
  parameter int unsigned VAL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [VAL_W-1:0] val_i,
  output logic             done_o,
  output logic [3:0]       hund_o,
  output logic [3:0]       tens_o,
  output logic [3:0]       ones_o
);
  typedef enum logic [1:0] {PH_IDLE, PH_HUND, PH_TENS} phase_e;

  phase_e           phase_q;
  logic [VAL_W-1:0] rem_q;
  logic [3:0]       hund_q, tens_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      rem_q   <= '0;
      hund_q  <= '0;
      tens_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (go_i) begin
          rem_q   <= val_i;
          hund_q  <= '0;
          tens_q  <= '0;
          phase_q <= PH_HUND;
        end
        PH_HUND: begin
          if (rem_q >= VAL_W'(100)) begin
            rem_q  <= rem_q - VAL_W'(100);
            hund_q <= hund_q + 4'd1;
          end else begin
            phase_q <= PH_TENS;
          end
        end
        PH_TENS: begin
          if (rem_q >= VAL_W'(10)) begin
            rem_q  <= rem_q - VAL_W'(10);
            tens_q <= tens_q + 4'd1;
          end else begin
            done_q  <= 1'b1;
            phase_q <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign hund_o = hund_q;
  assign tens_o = tens_q;
  assign ones_o = rem_q[3:0];

  AST_DIGIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (hund_q <= 4'd2) && (tens_q <= 4'd9) && (rem_q < VAL_W'(10))); // R4
endmodule

// File: rtl/cmd_line_char.sv
module cmd_line_char
  import cmd_fmt_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       cmd_i,
  input  logic [3:0]       hund_i,
  input  logic [3:0]       tens_i,
  input  logic [3:0]       ones_i,
  input  logic [1:0]       ndig_i,
  output logic [7:0]       char_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] HEX_HI   = IDX_W'(PREFIX_LEN);
  localparam logic [IDX_W-1:0] DIG_BASE = IDX_W'(PREFIX_LEN + 4);

  logic [IDX_W-1:0] k;
  logic [3:0]       dig;

  always_comb begin
    k = idx_i - DIG_BASE;
    // pick digit k of a number with ndig digits, most significant first
    case (ndig_i)
      2'd3:    dig = (k == 0) ? hund_i : ((k == 1) ? tens_i : ones_i);
      2'd2:    dig = (k == 0) ? tens_i : ones_i;
      default: dig = ones_i;
    endcase

    if (idx_i < HEX_HI)                char_o = prefix_char(idx_i);
    else if (idx_i == HEX_HI)          char_o = hex_ascii(cmd_i[7:4]);
    else if (idx_i == HEX_HI + 5'd1)   char_o = hex_ascii(cmd_i[3:0]);
    else if (idx_i == HEX_HI + 5'd2)   char_o = 8'h20;
    else if (idx_i == HEX_HI + 5'd3)   char_o = 8'h28;
    else if (k < IDX_W'(ndig_i))       char_o = 8'h30 + {4'h0, dig};
    else if (k == IDX_W'(ndig_i))      char_o = 8'h29;
    else if (k == IDX_W'(ndig_i) + 1)  char_o = 8'h0D;
    else                               char_o = 8'h0A;

    last_o = (k == IDX_W'(ndig_i) + 5'd2);
  end
endmodule

// File: rtl/cmd_report_fmt.sv
module cmd_report_fmt
  import cmd_fmt_pkg::*;
#(
  parameter int unsigned CMD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             busy_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i
);
  fmt_state_e       state_q;
  logic [CMD_W-1:0] cmd_q;
  logic [IDX_W-1:0] idx_q;
  logic             start_acc;
  logic             conv_done;
  logic [3:0]       hund, tens, ones;
  logic [1:0]       ndig;
  logic [7:0]       char_w;
  logic             last_w;

  assign start_acc = start_i && (state_q == ST_IDLE);

  cmd_bcd_split #(.VAL_W(CMD_W)) u_split (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (start_acc),
    .val_i  (cmd_i),
    .done_o (conv_done),
    .hund_o (hund),
    .tens_o (tens),
    .ones_o (ones)
  );

  assign ndig = (hund != 4'd0) ? 2'd3 : ((tens != 4'd0) ? 2'd2 : 2'd1);

  cmd_line_char u_char (
    .idx_i  (idx_q),
    .cmd_i  (cmd_q[7:0]),
    .hund_i (hund),
    .tens_i (tens),
    .ones_i (ones),
    .ndig_i (ndig),
    .char_o (char_w),
    .last_o (last_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_acc) begin
          cmd_q   <= cmd_i;
          state_q <= ST_CONV;
        end
        ST_CONV: if (conv_done) begin
          idx_q   <= '0;
          state_q <= ST_EMIT;
        end
        ST_EMIT: if (tx_ready_i) begin
          if (last_w) state_q <= ST_IDLE;
          else        idx_q   <= idx_q + 5'd1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign tx_valid_o = (state_q == ST_EMIT);
  assign tx_data_o  = char_w;

  AST_HOLD_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)); // R6
  AST_VALID_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> busy_o); // R7
  AST_DROP_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(cmd_q)); // R7
  AST_LF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && (tx_data_o == 8'h0A) |=> !busy_o); // R8
  AST_FIRST_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> (tx_data_o == 8'h4E)); // R2
endmodule

// File: tb/cmd_report_fmt_test.sv
module cmd_report_fmt_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic       ready = 1'b0;
  logic       busy, valid;
  logic [7:0] data;

  int checks = 0;
  int failures = 0;
  int unsigned lfsr = 32'h1234_5678;

  always #10 clk = ~clk;

  cmd_report_fmt uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .cmd_i      (cmd),
    .busy_o     (busy),
    .tx_data_o  (data),
    .tx_valid_o (valid),
    .tx_ready_i (ready)
  );

  logic [7:0] got [0:31];
  logic [7:0] exp [0:31];
  int got_len, exp_len;

  function automatic logic [7:0] hx(input int n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic build_exp(input int v);
    string pre = "NEC command: 0x";
    int n = 0;
    for (int i = 0; i < 15; i++) exp[n++] = pre[i];
    exp[n++] = hx(v / 16);
    exp[n++] = hx(v % 16);
    exp[n++] = 8'h20;
    exp[n++] = 8'h28;
    if (v >= 100) exp[n++] = 8'(48 + v / 100);
    if (v >= 10)  exp[n++] = 8'(48 + (v / 10) % 10);
    exp[n++] = 8'(48 + v % 10);
    exp[n++] = 8'h29;
    exp[n++] = 8'h0D;
    exp[n++] = 8'h0A;
    exp_len = n;
  endtask

  task automatic cmp_range(input int lo, input int hi, input string req);
    bit ok = 1'b1;
    int bad = lo;
    for (int i = lo; i <= hi; i++)
      if (ok && (i >= got_len || got[i] !== exp[i])) begin ok = 1'b0; bad = i; end
    check(ok, req, (bad < got_len) ? int'(got[bad]) : -1, int'(exp[bad]));
  endtask

  task automatic run_line(input int v, input bit poke);
    int cyc = 0;
    bit seen = 1'b0, hold = 1'b0, done = 1'b0;
    logic [7:0] hold_d = 8'h00;
    int nd = (v >= 100) ? 3 : ((v >= 10) ? 2 : 1);
    got_len = 0;
    build_exp(v);
    @(negedge clk);
    cmd = 8'(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R7 busy after start", int'(busy), 1);
    while (!done && cyc < 400) begin
      if (valid) begin
        if (!seen) begin
          seen = 1'b1;
          check(cyc <= 20, "R9 first byte latency", cyc, 20);
        end
      end
      if (hold) begin
        check(valid === 1'b1 && data === hold_d, "R6 stalled byte held", int'(data), int'(hold_d));
        hold = 1'b0;
      end
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      ready = (lfsr[1:0] != 2'b00);
      start = poke && (got_len == 6);
      cmd = poke ? 8'(v) ^ 8'hA5 : 8'(v);
      if (valid && ready) begin
        if (got_len < 32) got[got_len] = data;
        got_len++;
        if (data == 8'h0A) done = 1'b1;
      end else if (valid) begin
        hold = 1'b1;
        hold_d = data;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    ready = 1'b0;
    check(busy === 1'b0 && valid === 1'b0, "R8 idle after line feed", int'(busy), 0);
    cmp_range(0, 14, "R2 prefix");
    cmp_range(15, 16, "R3 hex digits");
    cmp_range(17, 18 + nd, poke ? "R7 R4 decimal after dropped start" : "R4 decimal");
    cmp_range(19 + nd, 21 + nd, "R5 terminator");
    check(got_len == exp_len, "R5 line length", got_len, exp_len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && valid === 1'b0, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && valid === 1'b0, "R1 idle after reset", int'(valid), 0);
    for (int v = 0; v < 256; v++) run_line(v, (v % 5) == 0);
    // back-to-back: new start right after the line feed is accepted
    run_line(7, 1'b0);
    run_line(255, 1'b0);
    run_line(100, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule